// File: doc/BRIEF.md
# Masked Beam-Position Comparator

This block decides whether a display coprocessor's wait or skip condition is satisfied. It compares the live raster position against a target position held in the two instruction words of a wait or skip. The comparison is greater-or-equal and covers only the bit positions that the instruction enables. An optional blitter-finished term gates the result. The live position is an 8-bit vertical counter and horizontal counter bits 8 down to 1.

The vertical field is the more significant part and the horizontal field the less significant part. Both are joined into one compound position. In the beam value and in the target, every bit whose enable is clear is forced to zero, and the two masked values are then compared as unsigned numbers. The most significant vertical bit has no enable and always takes part. The horizontal counter's lowest supplied bit (raster bit 1) is never compared.

The verdict is captured in a register on each memory-cycle strobe. It holds between strobes, so the instruction sequencer always samples a settled value.

Top module: `beam_cmp_top`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `cond_met` is 0.
- R2: `cond_met` takes a new value only on a rising clock edge where `cyc_en` is 1, one cycle after the inputs it reflects. With `cyc_en` at 0 it holds its value, whatever the other inputs do.
- R3: The target vertical position is `wd_first[15:8]`. The target horizontal position is `wd_first[7:1]`, which is compared with `beam_h[7:1]`. The compound value is {vertical, horizontal}, with vertical more significant, and the test is unsigned greater-or-equal.
- R4: `wd_second[14:8]` enable vertical bits 6..0 and `wd_second[7:1]` enable horizontal bits `beam_h[7:1]`, with 1 meaning compared. A disabled bit is zero in both the beam and the target values.
- R5: Vertical bit 7 is always compared. With every enable in `wd_second[14:1]` clear, the result is `beam_v[7] >= wd_first[15]`.
- R6: `beam_h[0]`, `wd_first[0]` and `wd_second[0]` have no effect on `cond_met`.
- R7: When `wd_second[15]` is 1, `blit_done` has no effect.
- R8: When `wd_second[15]` is 0, `cond_met` is 0 unless `blit_done` is 1 in the strobe cycle.
- R9: A masked beam position exactly equal to the masked target counts as met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Memory-cycle strobe; the result register loads when this is 1 |
| beam_v | input | 8 | Current vertical beam counter |
| beam_h | input | 8 | Horizontal beam counter bits 8..1 (bit 0 here is raster bit 1) |
| wd_first | input | 16 | First instruction word: target position |
| wd_second | input | 16 | Second instruction word: blitter-disable flag and enable masks |
| blit_done | input | 1 | Blitter-finished flag |
| cond_met | output | 1 | Registered wait/skip condition |

## Verification
Three conditions are hard to reach with free-running stimulus: an exact masked tie, the case where the sparse enables hide a large difference in the raw values, and the case where only the unmaskable vertical bit decides. Independent random words almost never produce them. The stimulus therefore builds targets by copying the beam value and flipping a few bits, some of them enabled and some disabled. It also runs directed steps with all enables clear and with equal masked values. The blitter flag and the strobe are toggled across these cases so that gating and holding are exercised on both verdicts.

// File: rtl/beam_cmp_pkg.sv
package beam_cmp_pkg;
  localparam int unsigned VERT_W = 8;
  localparam int unsigned HORZ_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned POS_W  = VERT_W + HORZ_W - 1;

  typedef logic [POS_W-1:0] pos_t;

  // zero every disabled bit of a compound position
  function automatic pos_t apply_mask(input pos_t value, input pos_t enables);
    return value & enables;
  endfunction

  // unsigned greater-or-equal over the enabled bits only
  function automatic logic masked_ge(input pos_t beam, input pos_t target, input pos_t enables);
    return apply_mask(beam, enables) >= apply_mask(target, enables);
  endfunction
endpackage

// File: rtl/beam_cmp_decode.sv
module beam_cmp_decode #(
  parameter int unsigned VW = beam_cmp_pkg::VERT_W,
  parameter int unsigned HW = beam_cmp_pkg::HORZ_W,
  parameter int unsigned WW = beam_cmp_pkg::WORD_W
) (
  input  logic [WW-1:0]      word_a,
  input  logic [WW-1:0]      word_b,
  output logic [VW+HW-2:0]   target,
  output logic [VW+HW-2:0]   enables,
  output logic               blit_bypass
);
  localparam int unsigned CW = VW + HW - 1;

  // target: vertical from the top of word_a, horizontal from its low bits above bit 0
  assign target = {word_a[WW-1 -: VW], word_a[HW-1:1]};

  // enables: top vertical bit fixed on, the rest taken from word_b
  for (genvar k = 0; k < CW; k++) begin : g_en
    if (k == CW - 1) begin : g_top
      assign enables[k] = 1'b1;
    end else if (k >= HW - 1) begin : g_vert
      assign enables[k] = word_b[k + (WW - VW - HW + 1)];
    end else begin : g_horz
      assign enables[k] = word_b[k + 1];
    end
  end

  assign blit_bypass = word_b[WW-1];
endmodule

// File: rtl/beam_cmp_ge.sv
module beam_cmp_ge #(
  parameter int unsigned VW = beam_cmp_pkg::VERT_W,
  parameter int unsigned HW = beam_cmp_pkg::HORZ_W
) (
  input  logic [VW-1:0]    v_now,
  input  logic [HW-1:0]    h_now,
  input  logic [VW+HW-2:0] target,
  input  logic [VW+HW-2:0] enables,
  output logic             at_or_past
);
  beam_cmp_pkg::pos_t beam_pos;

  assign beam_pos   = {v_now, h_now[HW-1:1]};
  assign at_or_past = beam_cmp_pkg::masked_ge(beam_pos, target, enables);
endmodule

// File: rtl/beam_cmp_top.sv
module beam_cmp_top #(
  parameter int unsigned VW = beam_cmp_pkg::VERT_W,
  parameter int unsigned HW = beam_cmp_pkg::HORZ_W,
  parameter int unsigned WW = beam_cmp_pkg::WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_en,
  input  logic [VW-1:0] beam_v,
  input  logic [HW-1:0] beam_h,
  input  logic [WW-1:0] wd_first,
  input  logic [WW-1:0] wd_second,
  input  logic          blit_done,
  output logic          cond_met
);
  localparam int unsigned CW = VW + HW - 1;

  logic [CW-1:0] tgt_pos;
  logic [CW-1:0] tgt_en;
  logic          blit_bypass;
  logic          pos_ge;
  logic          blit_ok;
  logic          cond_next;

  beam_cmp_decode #(.VW(VW), .HW(HW), .WW(WW)) dec_i (
    .word_a      (wd_first),
    .word_b      (wd_second),
    .target      (tgt_pos),
    .enables     (tgt_en),
    .blit_bypass (blit_bypass)
  );

  beam_cmp_ge #(.VW(VW), .HW(HW)) ge_i (
    .v_now      (beam_v),
    .h_now      (beam_h),
    .target     (tgt_pos),
    .enables    (tgt_en),
    .at_or_past (pos_ge)
  );

  assign blit_ok   = blit_bypass | blit_done;
  assign cond_next = pos_ge & blit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_met <= 1'b0;
    end else if (cyc_en) begin
      cond_met <= cond_next;
    end
  end
endmodule

// File: rtl/beam_cmp_chk.sv
module beam_cmp_chk #(
  parameter int unsigned VW = 8,
  parameter int unsigned HW = 8,
  parameter int unsigned WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_en,
  input logic [VW-1:0] beam_v,
  input logic [HW-1:0] beam_h,
  input logic [WW-1:0] wd_first,
  input logic [WW-1:0] wd_second,
  input logic          blit_done,
  input logic          pos_ge,
  input logic          blit_ok,
  input logic          cond_met
);
  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !cond_met); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en && $past(rst_n) |=> $stable(cond_met)); // R2

  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en |=> cond_met == $past(pos_ge && blit_ok)); // R2

  AST_BLIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && !wd_second[WW-1] && !blit_done |=> !cond_met); // R8

  AST_BLIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && wd_second[WW-1] |=> cond_met == $past(pos_ge)); // R7

  AST_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && wd_second[WW-1] && (wd_second[WW-2:1] == '0)
    |=> cond_met == $past(beam_v[VW-1] >= wd_first[WW-1])); // R5

  AST_TIE_MET: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && wd_second[WW-1] && (beam_v == wd_first[WW-1 -: VW])
    && (beam_h[HW-1:1] == wd_first[HW-1:1]) |=> cond_met); // R9
endmodule

bind beam_cmp_top beam_cmp_chk #(.VW(VW), .HW(HW), .WW(WW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_en    (cyc_en),
  .beam_v    (beam_v),
  .beam_h    (beam_h),
  .wd_first  (wd_first),
  .wd_second (wd_second),
  .blit_done (blit_done),
  .pos_ge    (pos_ge),
  .blit_ok   (blit_ok),
  .cond_met  (cond_met)
);

// File: tb/beam_cmp_top_tb.sv
module beam_cmp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b0;
  logic [7:0]  beam_v = '0;
  logic [7:0]  beam_h = '0;
  logic [15:0] wd_first = '0;
  logic [15:0] wd_second = '0;
  logic        blit_done = 1'b0;
  logic        cond_met;

  int checks = 0;
  int fails  = 0;
  bit exp_met = 1'b0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  beam_cmp_top dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .beam_v(beam_v), .beam_h(beam_h),
    .wd_first(wd_first), .wd_second(wd_second), .blit_done(blit_done), .cond_met(cond_met)
  );

  // reference: build both masked positions bit by bit as integers, MSB first
  function automatic bit ref_cond(input logic [7:0] v, input logic [7:0] h,
                                  input logic [15:0] a, input logic [15:0] b, input logic bd);
    int beam_num = 0;
    int tgt_num  = 0;
    for (int k = 7; k >= 0; k--) begin
      bit on = (k == 7) ? 1'b1 : b[8 + k];
      beam_num = beam_num * 2 + ((on && v[k]) ? 1 : 0);
      tgt_num  = tgt_num  * 2 + ((on && a[8 + k]) ? 1 : 0);
    end
    for (int k = 7; k >= 1; k--) begin
      bit on = b[k];
      beam_num = beam_num * 2 + ((on && h[k]) ? 1 : 0);
      tgt_num  = tgt_num  * 2 + ((on && a[k]) ? 1 : 0);
    end
    return (beam_num >= tgt_num) && (b[15] || bd);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) exp_met = 1'b0;
    else if (cyc_en) exp_met = ref_cond(beam_v, beam_h, wd_first, wd_second, blit_done);
  end

  task automatic check_out(input string req);
    checks++;
    if (cond_met !== exp_met) begin
      fails++;
      $display("FAIL %s: cond_met=%0b expected=%0b at %0t", req, cond_met, exp_met, $time);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic step(input logic [7:0] v, input logic [7:0] h, input logic [15:0] a,
                      input logic [15:0] b, input logic bd, input logic en, input string req);
    beam_v = v; beam_h = h; wd_first = a; wd_second = b; blit_done = bd; cyc_en = en; tag = req;
    @(posedge clk);
    @(negedge clk);
    check_out(req);
  endtask

  task automatic expect_val(input bit val, input string req);
    checks++;
    if (cond_met !== val) begin
      fails++;
      $display("FAIL %s: cond_met=%0b expected=%0b at %0t", req, cond_met, val, $time);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, with stimulus that would otherwise give 1
    @(negedge clk);
    beam_v = 8'hFF; beam_h = 8'hFF; wd_second = 16'h8000; cyc_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_val(1'b0, "R1");
    rst_n = 1'b1; cyc_en = 1'b0;
    @(negedge clk);
    expect_val(1'b0, "R1");

    // R9: exact tie with all enables on
    step(8'h40, 8'h22, {8'h40, 8'h22}, 16'hFFFE, 1'b0, 1'b1, "R9");
    expect_val(1'b1, "R9");
    // R3: horizontal one step behind the target -> not met
    step(8'h40, 8'h20, {8'h40, 8'h22}, 16'hFFFE, 1'b0, 1'b1, "R3");
    expect_val(1'b0, "R3");
    // R3: vertical dominates the horizontal field
    step(8'h41, 8'h00, {8'h40, 8'hFE}, 16'hFFFE, 1'b0, 1'b1, "R3");
    expect_val(1'b1, "R3");
    // R2: inputs flip to a failing case while the strobe is low -> hold 1
    step(8'h00, 8'h00, 16'hFFFE, 16'hFFFE, 1'b0, 1'b0, "R2");
    expect_val(1'b1, "R2");
    step(8'h00, 8'h00, 16'hFFFE, 16'hFFFE, 1'b0, 1'b1, "R2");
    expect_val(1'b0, "R2");
    // R4: beam behind only in disabled bits -> met
    step(8'h30, 8'h00, {8'h3F, 8'hFE}, 16'hF000, 1'b0, 1'b1, "R4");
    expect_val(1'b1, "R4");
    // R4: same values with vertical bit 3 enabled -> not met
    step(8'h30, 8'h00, {8'h3F, 8'hFE}, 16'hF800, 1'b0, 1'b1, "R4");
    expect_val(1'b0, "R4");
    // R5: all enables clear, top bits decide
    step(8'h7F, 8'hFF, {8'h80, 8'h00}, 16'h8000, 1'b0, 1'b1, "R5");
    expect_val(1'b0, "R5");
    step(8'h80, 8'h00, {8'hFF, 8'hFE}, 16'h8000, 1'b0, 1'b1, "R5");
    expect_val(1'b1, "R5");
    // R6: bit 0 of each word and of beam_h does not matter
    step(8'h10, 8'h10, {8'h10, 8'h11}, 16'hFFFF, 1'b0, 1'b1, "R6");
    expect_val(1'b1, "R6");
    step(8'h10, 8'h11, {8'h10, 8'h12}, 16'hFFFE, 1'b0, 1'b1, "R6");
    expect_val(1'b0, "R6");
    // R8: blitter gating when bypass is clear
    step(8'hFF, 8'hFE, 16'h0000, 16'h7FFE, 1'b0, 1'b1, "R8");
    expect_val(1'b0, "R8");
    step(8'hFF, 8'hFE, 16'h0000, 16'h7FFE, 1'b1, 1'b1, "R8");
    expect_val(1'b1, "R8");
    // R7: bypass set, blitter flag low, position behind and then ahead
    step(8'h01, 8'h00, 16'h0200, 16'hFFFE, 1'b0, 1'b1, "R7");
    expect_val(1'b0, "R7");
    step(8'h02, 8'h00, 16'h0200, 16'hFFFE, 1'b0, 1'b1, "R7");
    expect_val(1'b1, "R7");

    // mixed: targets near the beam, random enables, strobe and blitter
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  v  = 8'($urandom);
      logic [7:0]  h  = 8'($urandom);
      logic [15:0] a  = {v, h} ^ (16'h1 << ($urandom % 16)) ^ ((i % 3 == 0) ? 16'($urandom) : 16'h0);
      logic [15:0] b  = 16'($urandom) | ((i % 4 == 0) ? 16'h8000 : 16'h0);
      step(v, h, a, b, 1'($urandom), 1'($urandom), "R2 R3 R4 R7 R8 R9 mixed");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule